// File: doc/BRIEF.md
# Built-In Angle Self-Test Sequencer

The block runs a self-test over a group of angle-measuring channels. Software writes the control register to start a sweep. The sequencer then asserts an isolate output that cuts the channels off from their field inputs, and it drives a stimulus angle through 72 evenly spaced positions around the circle. Each position is held for a parameterised number of settle cycles. At the last settle cycle of each position, every active channel's measured angle is compared with the stimulus using a modular difference. Any channel whose error exceeds the tolerance loses its pass bit.

When the sweep completes, the start bit drops by itself and the per-channel pass bits can be read from the status register. If any active channel failed, a one-cycle failure pulse goes to the interrupt logic. Software can abort a sweep by writing the start bit back to zero. A separate manual mode also isolates the channels and drives a stimulus angle that software writes. That angle is preset to 30 degrees each time the mode is entered.

Angles are 16-bit unsigned binary fractions of a turn: 0x8000 is 180 degrees and 330 degrees is 0xEAAB. The analog stimulus and the measurement front end lie outside the block.

Top module: `angle_bist_seq`

## Requirements
- R1: A write to address 0 with bit 3 set, while no sweep runs, starts a sweep. On the next cycle `isolate` is 1 and bit 3 of address 0 reads 1.
- R2: During a sweep, step k (k = 0..71) drives `stimAngle` = round(k*65536/72). The first step appears right after the starting write, and each step is held for SETTLE cycles.
- R3: At the end of each step, a channel passes that step when the modular distance |measured - stimulus| (16-bit wrap) is at most 9 LSB (about 0.05 degrees). This includes measurements on the far side of the 0/360 wrap.
- R4: Address 2 reads the pass bits, with bit c for channel c: 1 = accuracy OK, 0 = failed. Channels whose `chActive` bit is 0 when the sweep starts read 0 and never cause a failure.
- R5: Bit 3 of address 0 returns to 0 by itself exactly 72*SETTLE cycles after the starting write. `isolate` then drops unless manual mode is on.
- R6: `failPulse` is 1 for exactly one cycle, the cycle in which bit 3 first reads 0 after a completed sweep, when any active channel failed a step. It stays 0 otherwise.
- R7: Writing address 0 with bit 3 clear during a sweep aborts it. On the next cycle bit 3 reads 0 and `isolate` is 0 (manual mode off), and no `failPulse` follows.
- R8: Bit 0 of address 0 selects manual mode, which holds `isolate` at 1. Entering manual mode sets `stimAngle` to 5461 (30 degrees). A write to address 1 sets the manual stimulus, and the value reads back at address 1.
- R9: After reset, addresses 0 and 2 read 0, and `isolate`, `failPulse` and `stimAngle` are 0.
- R10: Writes to address 2 have no effect on the status it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 control, 1 manual angle, 2 status) |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Read data, combinational from rdAddr |
| chActive | input | NUM_CH | Channels to be tested, sampled at sweep start |
| measAngles | input | NUM_CH*16 | Measured angle of each channel, channel c in bits [16c+15:16c] |
| stimAngle | output | 16 | Stimulus angle toward the channels |
| isolate | output | 1 | Disconnects channels from their outside inputs |
| failPulse | output | 1 | One-cycle failure event toward the interrupt logic |

## Verification
Suppose the step counter or the fractional accumulator takes a wrong value. The stimulus would then leave the exact rounded sequence at the next step boundary, so the bench checks every step of one sweep. A wrong settle count shifts the step boundaries, and it also moves the end of the sweep away from exactly 72*SETTLE cycles; the bench samples the cycle just before the end and the cycle of the end. A lost or stuck pass bit, an inverted wrap in the distance, or a misjudged tolerance edge appears in the status word and in the failure pulse as soon as the sweep ends. The error table exercises ±9, ±10 and half-turn errors for that reason.

// File: rtl/angle_bist_pkg.sv
package angle_bist_pkg;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_MANUAL = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam int SWEEP_BIT  = 3;
  localparam int MANUAL_BIT = 0;

  typedef struct packed {
    logic start;
    logic compare;
    logic finish;
    logic manualEnter;
    logic sweepOn;
    logic manualOn;
  } seqStrobes_t;

endpackage

// File: rtl/angle_bist_ctrl.sv
module angle_bist_ctrl
  import angle_bist_pkg::*;
#(
  parameter int STEPS  = 72,
  parameter int SETTLE = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output seqStrobes_t       stb
);

  localparam int IDX_W = $clog2(STEPS + 1);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE - 1);

  logic             sweepBit;
  logic             manualBit;
  logic [IDX_W-1:0] stepIdx;
  logic [CNT_W-1:0] settleCnt;
  logic             ctrlWr;
  logic             abortReq;

  always_comb begin
    ctrlWr          = wrEn && (wrAddr == ADDR_CTRL);
    abortReq        = ctrlWr && !wrData[SWEEP_BIT] && sweepBit;
    stb.start       = ctrlWr && wrData[SWEEP_BIT] && !sweepBit;
    stb.compare     = sweepBit && !abortReq && (settleCnt == LAST_CNT);
    stb.finish      = stb.compare && (stepIdx == LAST_IDX);
    stb.manualEnter = ctrlWr && wrData[MANUAL_BIT] && !manualBit;
    stb.sweepOn     = sweepBit;
    stb.manualOn    = manualBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sweepBit  <= 1'b0;
      manualBit <= 1'b0;
      stepIdx   <= '0;
      settleCnt <= '0;
    end else begin
      if (ctrlWr) manualBit <= wrData[MANUAL_BIT];
      if (stb.start) begin
        sweepBit  <= 1'b1;
        stepIdx   <= '0;
        settleCnt <= '0;
      end else if (abortReq) begin
        sweepBit <= 1'b0;
      end else if (sweepBit) begin
        if (settleCnt == LAST_CNT) begin
          settleCnt <= '0;
          if (stepIdx == LAST_IDX) sweepBit <= 1'b0;
          else stepIdx <= stepIdx + 1'b1;
        end else begin
          settleCnt <= settleCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/angle_bist_dp.sv
module angle_bist_dp
  import angle_bist_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ANGLE_W     = 16,
  parameter int STEPS       = 72,
  parameter int TOL_LSB     = 9,
  parameter int DEFAULT_DEG = 30
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobes_t               stb,
  input  logic                      wrEn,
  input  logic [1:0]                wrAddr,
  input  logic [ANGLE_W-1:0]        wrData,
  input  logic [1:0]                rdAddr,
  output logic [ANGLE_W-1:0]        rdData,
  input  logic [NUM_CH-1:0]         chActive,
  input  logic [NUM_CH*ANGLE_W-1:0] measAngles,
  output logic [ANGLE_W-1:0]        stimAngle,
  output logic [NUM_CH-1:0]         passBits,
  output logic                      failPulse
);

  localparam longint FULL  = longint'(1) << ANGLE_W;
  localparam int     WHOLE = int'(FULL / STEPS);
  localparam int     FRAC  = int'(FULL % STEPS);
  localparam int     REM_W = $clog2(2 * STEPS);
  localparam logic [ANGLE_W-1:0] DEF_ANGLE =
    ANGLE_W'((longint'(DEFAULT_DEG) * FULL + 180) / 360);
  localparam logic [ANGLE_W-1:0] TOL = ANGLE_W'(TOL_LSB);

  logic [ANGLE_W-1:0] sweepAngle;
  logic [REM_W-1:0]   remAcc;
  logic [REM_W-1:0]   remSum;
  logic [ANGLE_W-1:0] manualAngle;
  logic [NUM_CH-1:0]  activeReg;
  logic [NUM_CH-1:0]  chBad;
  logic [NUM_CH-1:0]  passNext;

  assign remSum    = remAcc + REM_W'(FRAC);
  assign stimAngle = stb.sweepOn ? sweepAngle : manualAngle;

  // Fractional step accumulator: angle k = round(k*FULL/STEPS)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sweepAngle <= '0;
      remAcc     <= REM_W'(STEPS / 2);
    end else if (stb.start) begin
      sweepAngle <= '0;
      remAcc     <= REM_W'(STEPS / 2);
    end else if (stb.compare && !stb.finish) begin
      if (remSum >= REM_W'(STEPS)) begin
        remAcc     <= remSum - REM_W'(STEPS);
        sweepAngle <= sweepAngle + ANGLE_W'(WHOLE + 1);
      end else begin
        remAcc     <= remSum;
        sweepAngle <= sweepAngle + ANGLE_W'(WHOLE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) manualAngle <= '0;
    else if (stb.manualEnter) manualAngle <= DEF_ANGLE;
    else if (wrEn && wrAddr == ADDR_MANUAL) manualAngle <= wrData;
  end

  // One modular-distance comparator per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    logic [ANGLE_W-1:0] diff;
    logic [ANGLE_W-1:0] mag;
    always_comb begin
      diff     = measAngles[c*ANGLE_W +: ANGLE_W] - stimAngle;
      mag      = diff[ANGLE_W-1] ? (~diff + 1'b1) : diff;
      chBad[c] = mag > TOL;
    end
  end

  assign passNext = passBits & ~(chBad & activeReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      passBits  <= '0;
      activeReg <= '0;
      failPulse <= 1'b0;
    end else begin
      failPulse <= stb.finish && |(activeReg & ~passNext);
      if (stb.start) begin
        passBits  <= chActive;
        activeReg <= chActive;
      end else if (stb.compare) begin
        passBits <= passNext;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL: begin
        rdData[SWEEP_BIT]  = stb.sweepOn;
        rdData[MANUAL_BIT] = stb.manualOn;
      end
      ADDR_MANUAL: rdData = manualAngle;
      ADDR_STATUS: rdData[NUM_CH-1:0] = passBits;
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/angle_bist_seq.sv
module angle_bist_seq
  import angle_bist_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ANGLE_W     = 16,
  parameter int STEPS       = 72,
  parameter int SETTLE      = 4,
  parameter int TOL_LSB     = 9,
  parameter int DEFAULT_DEG = 30
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [1:0]                wrAddr,
  input  logic [ANGLE_W-1:0]        wrData,
  input  logic [1:0]                rdAddr,
  output logic [ANGLE_W-1:0]        rdData,
  input  logic [NUM_CH-1:0]         chActive,
  input  logic [NUM_CH*ANGLE_W-1:0] measAngles,
  output logic [ANGLE_W-1:0]        stimAngle,
  output logic                      isolate,
  output logic                      failPulse
);

  seqStrobes_t       stb;
  logic [NUM_CH-1:0] passBits;

  angle_bist_ctrl #(.STEPS(STEPS), .SETTLE(SETTLE), .DATA_W(ANGLE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .stb(stb)
  );

  angle_bist_dp #(
    .NUM_CH(NUM_CH), .ANGLE_W(ANGLE_W), .STEPS(STEPS),
    .TOL_LSB(TOL_LSB), .DEFAULT_DEG(DEFAULT_DEG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .chActive(chActive), .measAngles(measAngles),
    .stimAngle(stimAngle), .passBits(passBits), .failPulse(failPulse)
  );

  assign isolate = stb.sweepOn | stb.manualOn;

endmodule

// File: rtl/angle_bist_seq_chk.sv
module angle_bist_seq_chk
  import angle_bist_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ANGLE_W     = 16,
  parameter int STEPS       = 72,
  parameter int DEFAULT_DEG = 30
) (
  input logic               clk,
  input logic               rstN,
  input seqStrobes_t        stb,
  input logic [ANGLE_W-1:0] stimAngle,
  input logic [NUM_CH-1:0]  passBits,
  input logic               failPulse
);

  localparam longint FULL = longint'(1) << ANGLE_W;
  localparam logic [ANGLE_W-1:0] WHOLE  = ANGLE_W'(FULL / STEPS);
  localparam logic [ANGLE_W-1:0] WHOLE1 = ANGLE_W'(FULL / STEPS + 1);
  localparam logic [ANGLE_W-1:0] DEF_ANGLE =
    ANGLE_W'((longint'(DEFAULT_DEG) * FULL + 180) / 360);

  // R2: stimulus held inside a step
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sweepOn && !stb.compare) |=> (!stb.sweepOn || $stable(stimAngle)));

  // R2: step size is the whole part or one more
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.compare && !stb.finish) |=>
      (!stb.sweepOn || (ANGLE_W'(stimAngle - $past(stimAngle)) == WHOLE)
                    || (ANGLE_W'(stimAngle - $past(stimAngle)) == WHOLE1)));

  // R4: pass bits are never regained during a sweep
  a_r4_no_regain: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.sweepOn) && stb.sweepOn) |-> ((passBits & ~$past(passBits)) == '0));

  // R6: failure event is a single cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |=> !failPulse);

  // R6: failure event only right after a completed sweep
  a_r6_after_finish: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |-> (!stb.sweepOn && $past(stb.finish)));

  // R8: entering manual mode loads the default angle
  a_r8_default: assert property (@(posedge clk) disable iff (!rstN)
    (stb.manualEnter && !stb.sweepOn && !stb.start) |=> (stimAngle == DEF_ANGLE));

endmodule

bind angle_bist_seq angle_bist_seq_chk #(
  .NUM_CH(NUM_CH), .ANGLE_W(ANGLE_W), .STEPS(STEPS), .DEFAULT_DEG(DEFAULT_DEG)
) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .stimAngle(stimAngle),
  .passBits(passBits), .failPulse(failPulse)
);

// File: tb/angle_bist_seq_bench.sv
module angle_bist_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int W      = 16;
  localparam int STEPS  = 72;
  localparam int SETTLE = 4;
  localparam int NVEC   = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrAddr = '0;
  logic [W-1:0]      wrData = '0;
  logic [1:0]        rdAddr = '0;
  logic [W-1:0]      rdData;
  logic [NUM_CH-1:0] chActive = '1;
  logic [NUM_CH*W-1:0] measAngles;
  logic [W-1:0]      stimAngle;
  logic              isolate;
  logic              failPulse;
  logic [W-1:0]      chErr [NUM_CH];

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  angle_bist_seq u_angle_bist_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .chActive(chActive), .measAngles(measAngles),
    .stimAngle(stimAngle), .isolate(isolate), .failPulse(failPulse)
  );

  // Front-end model: each channel measures the stimulus plus its own error
  always_comb
    for (int c = 0; c < NUM_CH; c++) measAngles[c*W +: W] = stimAngle + chErr[c];

  // Error table: per vector, per channel error, active mask, expected status, expected fail
  localparam logic [W-1:0] VEC_ERR [NVEC][NUM_CH] = '{
    '{16'd0,   16'd0,    16'd0,    16'd0},
    '{16'd9,   16'hFFF7, 16'd0,    16'd9},
    '{16'd0,   16'd10,   16'd0,    16'd0},
    '{16'd0,   16'd0,    16'hFFF6, 16'd0},
    '{16'd500, 16'd0,    16'd0,    16'd500},
    '{16'd0,   16'd0,    16'd0,    16'h8000}
  };
  localparam logic [NUM_CH-1:0] VEC_ACT  [NVEC] = '{4'b1111, 4'b1111, 4'b1111, 4'b1111, 4'b0110, 4'b1111};
  localparam logic [NUM_CH-1:0] VEC_STAT [NVEC] = '{4'b1111, 4'b1111, 4'b1101, 4'b1011, 4'b0110, 4'b0111};
  localparam logic              VEC_FAIL [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [W-1:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  function automatic logic [W-1:0] expAngle(input int k);
    return W'((longint'(k) * 65536 + STEPS/2) / STEPS);
  endfunction

  // Run one full sweep from the starting write; checkStim checks every step (R2)
  task automatic runSweep(input bit checkStim, input logic [NUM_CH-1:0] expStat,
                          input logic expFail);
    logic [W-1:0] rv;
    bit sawEarlyFail = 1'b0;
    wrReg(2'd0, 16'h0008);
    rdReg(2'd0, rv);
    check(rv[3] == 1'b1, "R1 start bit", rv, 16'h0008);
    check(isolate == 1'b1, "R1 isolate", isolate, 1);
    for (int k = 0; k < STEPS; k++) begin
      if (checkStim) check(stimAngle == expAngle(k), "R2 step angle", stimAngle, expAngle(k));
      repeat (SETTLE - 1) begin
        if (failPulse) sawEarlyFail = 1'b1;
        @(negedge clk);
      end
      if (k == STEPS - 1) begin
        rdReg(2'd0, rv);
        check(rv[3] == 1'b1, "R5 bit3 held until last cycle", rv[3], 1);
      end
      if (failPulse) sawEarlyFail = 1'b1;
      @(negedge clk);
    end
    check(!sawEarlyFail, "R6 no pulse during sweep", sawEarlyFail, 0);
    rdReg(2'd0, rv);
    check(rv[3] == 1'b0, "R5 bit3 self-clear", rv[3], 0);
    check(isolate == 1'b0, "R5 isolate released", isolate, 0);
    check(failPulse == expFail, "R6 fail pulse", failPulse, expFail);
    rdReg(2'd2, rv);
    check(rv == W'(expStat), "R3 R4 status", rv, expStat);
    @(negedge clk);
    check(failPulse == 1'b0, "R6 pulse width", failPulse, 0);
  endtask

  initial begin
    logic [W-1:0] rv;
    bit sawFail;
    for (int c = 0; c < NUM_CH; c++) chErr[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    rdReg(2'd0, rv); check(rv == 0, "R9 control", rv, 0);
    rdReg(2'd2, rv); check(rv == 0, "R9 status", rv, 0);
    check(isolate == 0, "R9 isolate", isolate, 0);
    check(failPulse == 0, "R9 failPulse", failPulse, 0);
    check(stimAngle == 0, "R9 stimAngle", stimAngle, 0);

    // Table of error patterns
    for (int v = 0; v < NVEC; v++) begin
      for (int c = 0; c < NUM_CH; c++) chErr[c] = VEC_ERR[v][c];
      chActive = VEC_ACT[v];
      runSweep(v == 0, VEC_STAT[v], VEC_FAIL[v]);
    end

    // R10: status write ignored (last vector left 0111)
    wrReg(2'd2, 16'hFFFF);
    rdReg(2'd2, rv);
    check(rv == 16'h0007, "R10 status write ignored", rv, 16'h0007);

    // R7: abort mid-sweep with a faulty channel
    chActive = 4'b1111;
    chErr[0] = 16'd100;
    wrReg(2'd0, 16'h0008);
    repeat (20) @(negedge clk);
    wrReg(2'd0, 16'h0000);
    rdReg(2'd0, rv);
    check(rv[3] == 1'b0, "R7 abort clears bit3", rv[3], 0);
    check(isolate == 1'b0, "R7 abort releases isolate", isolate, 0);
    sawFail = 1'b0;
    for (int i = 0; i < STEPS * SETTLE + 10; i++) begin
      if (failPulse) sawFail = 1'b1;
      @(negedge clk);
    end
    check(!sawFail, "R7 no pulse after abort", sawFail, 0);
    chErr[0] = '0;

    // R8: manual mode
    wrReg(2'd0, 16'h0001);
    check(stimAngle == 16'd5461, "R8 default 30 degrees", stimAngle, 5461);
    check(isolate == 1'b1, "R8 isolate", isolate, 1);
    wrReg(2'd1, 16'hEAAB);
    check(stimAngle == 16'hEAAB, "R8 written angle", stimAngle, 16'hEAAB);
    rdReg(2'd1, rv);
    check(rv == 16'hEAAB, "R8 readback", rv, 16'hEAAB);
    wrReg(2'd0, 16'h0000);
    check(isolate == 1'b0, "R8 exit", isolate, 0);
    wrReg(2'd0, 16'h0001);
    check(stimAngle == 16'd5461, "R8 default on re-entry", stimAngle, 5461);
    wrReg(2'd0, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule